// File: doc/BRIEF.md
# Configurable Quasi-Bidirectional Port Controller

This block controls one 8-bit general-purpose I/O port of a small microcontroller. Each pin has its own output type, chosen by one bit in each of two configuration registers. The four types are open-drain, quasi-bidirectional, high-impedance and push-pull. The block keeps an output latch and turns its contents into four driver enables per pin: a strong pull-up, a weak pull-up, a very weak keeper pull-up and an n-channel pull-down. The analog pad itself sits outside the block and resolves these enables.

Software reaches the block through a byte write port addressed by a small register address, plus a single-bit write path into the latch. Reads of the port address return the pad levels after a two-flop synchroniser, not the latch. A per-pin alternate-function output can be routed onto a pin. It is gated by the latch bit, so a latch 0 always pulls the pin low. A parameter mask marks pins that only support open-drain and high-impedance, such as pins shared with a two-wire serial bus. On those pins the other two mode codes fall back to a permitted type.

In quasi-bidirectional mode, a rising edge of a pin's driven value turns on the strong pull-up for a short burst, two clocks by default. After the burst, only the weak and keeper pull-ups hold the high level.

Top module: `qb_port_ctrl`

## Requirements
- R1: After reset the latch holds all ones and both configuration registers read 0. Every pin is therefore open-drain with latch 1, and all four driver enables are 0.
- R2: A byte write to address 1 loads configuration register A, and a byte write to address 2 loads register B. Reading either address returns the stored value. A byte write to address 0 loads the latch. Pin n's mode is {B[n],A[n]}.
- R3: Mode 00 (open-drain): the pull-down is on exactly when the driven value is 0, and all three pull-ups stay off.
- R4: Mode 01 (quasi-bidirectional): the pull-down is on when the driven value is 0, and the weak and keeper pull-ups are on when it is 1. A 0-to-1 change turns the strong pull-up on for exactly 2 clocks, starting in the cycle the new latch value is visible. Writing 1 over an existing 1 gives no burst.
- R5: If the driven value returns to 0 during a strong burst, the strong pull-up goes off and the pull-down comes on in the first cycle the 0 is visible.
- R6: Mode 10 (high-impedance): all four enables are 0, whatever the latch holds.
- R7: Mode 11 (push-pull): the strong pull-up equals the driven value and the pull-down is its inverse. Neither is time-limited.
- R8: When alt_en[n] is 1, pin n's driven value is latch[n] AND alt_out[n]. A latch 0 therefore forces the pin low whatever alt_out holds.
- R9: On pins set in the restricted mask (default bits 7 and 6), mode code 01 behaves as 00 and code 11 behaves as 10. No pull-up is ever enabled on these pins.
- R10: A single-bit write sets latch[bit_sel] to bit_val and leaves the other bits unchanged. If it coincides with a byte write to address 0, the single-bit write wins for its bit.
- R11: Reading address 0 returns the pad levels through two flops. A pad change is not visible after one clock edge and is visible after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Byte write strobe |
| bus_addr | input | 2 | Register address (0 port, 1 config A, 2 config B) |
| bus_wdata | input | 8 | Byte write data |
| bit_we | input | 1 | Single-bit latch write strobe |
| bit_sel | input | 3 | Latch bit index for the single-bit write |
| bit_val | input | 1 | Value for the single-bit write |
| rd_data | output | 8 | Read data for bus_addr |
| alt_en | input | 8 | Per-pin alternate-function select |
| alt_out | input | 8 | Per-pin alternate-function output value |
| pad_in | input | 8 | Pad levels seen at the pins |
| strong_pu | output | 8 | Strong pull-up enables |
| weak_pu | output | 8 | Weak pull-up enables |
| keep_pu | output | 8 | Keeper pull-up enables |
| pull_dn | output | 8 | N-channel pull-down enables |

## Verification
The bench models the pad as a resolved level and sets every mode on all pins at once. It then writes latch patterns such as 00, 0F, 3F and F0 to tell pins that drive from pins that float, and to expose any swap between the A and B bits. In quasi-bidirectional mode it counts the strong pull-up cycles after a rising write, after a repeated 1, and after a fall in mid-burst. Together these separate a burst that is too long, too short or retriggered. The restricted pins get the codes 01 and 11 to show the fallback. The synchroniser is sampled after one and after two edges, and a write that sets both paths at once settles which path wins.

// File: rtl/qb_port_ctrl.sv
module qb_port_ctrl #(
  parameter int WIDTH = 8,
  parameter int BURST_CYCLES = 2,
  parameter int AW = 2,
  parameter logic [WIDTH-1:0] LOCK_MASK = 8'hC0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_we,
  input  logic [AW-1:0]            bus_addr,
  input  logic [WIDTH-1:0]         bus_wdata,
  input  logic                     bit_we,
  input  logic [$clog2(WIDTH)-1:0] bit_sel,
  input  logic                     bit_val,
  output logic [WIDTH-1:0]         rd_data,
  input  logic [WIDTH-1:0]         alt_en,
  input  logic [WIDTH-1:0]         alt_out,
  input  logic [WIDTH-1:0]         pad_in,
  output logic [WIDTH-1:0]         strong_pu,
  output logic [WIDTH-1:0]         weak_pu,
  output logic [WIDTH-1:0]         keep_pu,
  output logic [WIDTH-1:0]         pull_dn
);
  localparam int CW = $clog2(BURST_CYCLES + 1);
  localparam logic [AW-1:0] A_PORT = AW'(0);
  localparam logic [AW-1:0] A_CFGA = AW'(1);
  localparam logic [AW-1:0] A_CFGB = AW'(2);
  localparam logic [1:0] M_OD = 2'b00, M_QB = 2'b01, M_HZ = 2'b10, M_PP = 2'b11;

  logic [WIDTH-1:0] latch_q, latch_d, cfga_q, cfgb_q, drv_prev_q, sync1_q, sync2_q;
  logic [WIDTH-1:0] drv, rise;

  always_comb begin
    latch_d = latch_q;
    if (bus_we && bus_addr == A_PORT) latch_d = bus_wdata;
    if (bit_we) latch_d[bit_sel] = bit_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q    <= '1;
      cfga_q     <= '0;
      cfgb_q     <= '0;
      drv_prev_q <= '1;
      sync1_q    <= '0;
      sync2_q    <= '0;
    end else begin
      latch_q    <= latch_d;
      drv_prev_q <= drv;
      sync1_q    <= pad_in;
      sync2_q    <= sync1_q;
      if (bus_we && bus_addr == A_CFGA) cfga_q <= bus_wdata;
      if (bus_we && bus_addr == A_CFGB) cfgb_q <= bus_wdata;
    end
  end

  always_comb begin
    case (bus_addr)
      A_PORT:  rd_data = sync2_q;
      A_CFGA:  rd_data = cfga_q;
      A_CFGB:  rd_data = cfgb_q;
      default: rd_data = '0;
    endcase
  end

  assign drv  = latch_q & (~alt_en | alt_out);
  assign rise = drv & ~drv_prev_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    logic [1:0]    mode;
    logic [CW-1:0] cnt_q;
    logic          burst;

    assign mode  = {cfgb_q[i], cfga_q[i] & ~LOCK_MASK[i]};
    assign burst = rise[i] || (cnt_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (rise[i])  cnt_q <= CW'(BURST_CYCLES - 1);
      else if (!drv[i])  cnt_q <= '0;
      else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    always_comb begin
      strong_pu[i] = 1'b0;
      weak_pu[i]   = 1'b0;
      keep_pu[i]   = 1'b0;
      pull_dn[i]   = 1'b0;
      case (mode)
        M_OD: pull_dn[i] = ~drv[i];
        M_QB: begin
          pull_dn[i]   = ~drv[i];
          weak_pu[i]   = drv[i];
          keep_pu[i]   = drv[i];
          strong_pu[i] = drv[i] & burst;
        end
        M_PP: begin
          strong_pu[i] = drv[i];
          pull_dn[i]   = ~drv[i];
        end
        default: ;
      endcase
    end

    logic [CW-1:0] run_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_q <= '0;
      else if (strong_pu[i] && mode == M_QB)
        run_q <= (run_q == CW'(BURST_CYCLES)) ? run_q : run_q + 1'b1;
      else run_q <= '0;
    end

    p_burst_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (strong_pu[i] && mode == M_QB) |-> (run_q < CW'(BURST_CYCLES)));

    if (LOCK_MASK[i]) begin : g_lock
      p_lock_no_pullup_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(strong_pu[i] || weak_pu[i] || keep_pu[i]));
    end
  end

  p_no_fight_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((strong_pu | weak_pu | keep_pu) & pull_dn) == '0);

  p_byte_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_PORT && !bit_we) |=> latch_q == $past(bus_wdata));

  p_bit_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bit_we |=> latch_q[$past(bit_sel)] == $past(bit_val));

  p_sync_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> sync2_q == $past(sync1_q));
endmodule

// File: tb/test_qb_port_ctrl.sv
`timescale 1ns/1ps
module test_qb_port_ctrl;
  localparam logic [7:0] LOCK = 8'hC0;
  logic clk = 0, rst_n = 0;
  logic bus_we = 0, bit_we = 0, bit_val = 0;
  logic [1:0] bus_addr = 0;
  logic [2:0] bit_sel = 0;
  logic [7:0] bus_wdata = 0, alt_en = 0, alt_out = 0, ext_lvl = 0;
  logic [7:0] rd_data, strong_pu, weak_pu, keep_pu, pull_dn;
  wire  [7:0] pad_in = ~pull_dn & ((strong_pu | weak_pu | keep_pu) | ext_lvl);
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  qb_port_ctrl i_qb_port_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bit_we(bit_we), .bit_sel(bit_sel), .bit_val(bit_val),
    .rd_data(rd_data), .alt_en(alt_en), .alt_out(alt_out), .pad_in(pad_in),
    .strong_pu(strong_pu), .weak_pu(weak_pu), .keep_pu(keep_pu), .pull_dn(pull_dn));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0; #1;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    bus_addr = a; #1; d = rd_data;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 strong", strong_pu, 8'h00);
    chk("R1 weak", weak_pu, 8'h00);
    chk("R1 keep", keep_pu, 8'h00);
    chk("R1 pull_dn", pull_dn, 8'h00);
    rd(2'd1, v); chk("R1 cfgA", v, 8'h00);
    rd(2'd2, v); chk("R1 cfgB", v, 8'h00);
  endtask

  task automatic t_regs;
    logic [7:0] v;
    wr(2'd1, 8'h96); wr(2'd2, 8'h3C);
    rd(2'd1, v); chk("R2 cfgA readback", v, 8'h96);
    rd(2'd2, v); chk("R2 cfgB readback", v, 8'h3C);
  endtask

  task automatic t_od;
    wr(2'd1, 8'h00); wr(2'd2, 8'h00);
    wr(2'd0, 8'h0F);
    chk("R3 od pull_dn", pull_dn, 8'hF0);
    chk("R3 od pullups", strong_pu | weak_pu | keep_pu, 8'h00);
  endtask

  task automatic t_qb;
    wr(2'd0, 8'h00); wr(2'd1, 8'hFF); wr(2'd2, 8'h00);
    chk("R4 qb low pull_dn", pull_dn, 8'hFF);
    wr(2'd0, 8'h0F);
    chk("R4 burst cycle1", strong_pu, 8'h0F);
    chk("R4 weak", weak_pu, 8'h0F);
    chk("R4 keep", keep_pu, 8'h0F);
    @(negedge clk); #1 chk("R4 burst cycle2", strong_pu, 8'h0F);
    @(negedge clk); #1 chk("R4 burst ended", strong_pu, 8'h00);
    chk("R4 weak holds", weak_pu, 8'h0F);
    wr(2'd0, 8'h0F);
    chk("R4 no retrigger", strong_pu, 8'h00);
  endtask

  task automatic t_qb_fall;
    wr(2'd0, 8'h00);
    bit_sel = 3'd2; bit_val = 1;
    @(negedge clk); bit_we = 1;
    @(negedge clk); bit_val = 0; #1;
    chk("R5 burst started", strong_pu, 8'h04);
    @(negedge clk); bit_we = 0; #1;
    chk("R5 strong cut", strong_pu, 8'h00);
    chk("R5 pull_dn now", pull_dn, 8'hFF);
  endtask

  task automatic t_hiz;
    wr(2'd1, 8'h00); wr(2'd2, 8'hFF);
    wr(2'd0, 8'h00);
    chk("R6 hiz low", strong_pu | weak_pu | keep_pu | pull_dn, 8'h00);
    wr(2'd0, 8'hFF);
    chk("R6 hiz high", strong_pu | weak_pu | keep_pu | pull_dn, 8'h00);
  endtask

  task automatic t_sync;
    logic [7:0] v;
    ext_lvl = 8'h00;
    repeat (3) @(negedge clk);
    rd(2'd0, v); chk("R11 idle", v, 8'h00);
    @(negedge clk); ext_lvl = 8'hA5;
    @(negedge clk); rd(2'd0, v); chk("R11 one edge", v, 8'h00);
    @(negedge clk); rd(2'd0, v); chk("R11 two edges", v, 8'hA5);
    ext_lvl = 8'h00;
  endtask

  task automatic t_pp;
    wr(2'd1, 8'hFF); wr(2'd2, 8'hFF);
    wr(2'd0, 8'h35);
    chk("R7 pp strong", strong_pu, 8'h35 & ~LOCK);
    chk("R7 pp pull_dn", pull_dn, ~8'h35 & ~LOCK);
    repeat (4) @(negedge clk); #1;
    chk("R7 pp strong held", strong_pu, 8'h35 & ~LOCK);
  endtask

  task automatic t_alt;
    wr(2'd0, 8'hFF);
    @(negedge clk); alt_en = 8'h04; alt_out = 8'h00; #1;
    chk("R8 alt low", strong_pu & 8'h04, 8'h00);
    chk("R8 alt low dn", pull_dn & 8'h04, 8'h04);
    @(negedge clk); alt_out = 8'h04; #1;
    chk("R8 alt high", strong_pu & 8'h04, 8'h04);
    wr(2'd0, 8'hFB);
    chk("R8 latch0 forces low", pull_dn & 8'h04, 8'h04);
    @(negedge clk); alt_en = 0; alt_out = 0;
  endtask

  task automatic t_restrict;
    wr(2'd1, 8'hC0); wr(2'd2, 8'h00);
    wr(2'd0, 8'h3F);
    chk("R9 01 as od low", pull_dn & LOCK, 8'hC0);
    wr(2'd0, 8'hFF);
    chk("R9 01 no pullup", (strong_pu | weak_pu | keep_pu) & LOCK, 8'h00);
    wr(2'd2, 8'hC0);
    wr(2'd0, 8'h00);
    chk("R9 11 as hiz", (strong_pu | pull_dn) & LOCK, 8'h00);
  endtask

  task automatic t_bitwr;
    wr(2'd1, 8'hFF); wr(2'd2, 8'hFF);
    wr(2'd0, 8'h00);
    @(negedge clk); bus_we = 1; bus_addr = 0; bus_wdata = 8'hF0;
    bit_we = 1; bit_sel = 3'd1; bit_val = 1;
    @(negedge clk); bus_we = 0; bit_we = 0; #1;
    chk("R10 bit wins with byte", strong_pu, 8'hF2 & ~LOCK);
    @(negedge clk); bit_we = 1; bit_sel = 3'd4; bit_val = 0;
    @(negedge clk); bit_we = 0; #1;
    chk("R10 single bit clear", strong_pu, 8'hE2 & ~LOCK);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    t_reset;
    t_regs;
    t_od;
    t_qb;
    t_qb_fall;
    t_hiz;
    t_sync;
    t_pp;
    t_alt;
    t_restrict;
    t_bitwr;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule